// File: doc/BRIEF.md
# Masked interrupt status controller

This block gathers up to 32 single-cycle event pulses into a sticky raw status register. Each raw bit is ANDed with a per-bit enable to form the masked status. The OR of the masked status, registered once, drives one interrupt request line toward the host.

The host works through a small register bus with a 2-bit word address. It reads the masked status to find which source raised the request and acknowledges by writing ones to the bits it has serviced. The enable register has no plain write port. Bits are turned on through a set address and turned off through a clear address, so one source can be changed without a read-modify-write. While any enabled raw bit is still pending, the request line stays asserted, or asserts again after an acknowledge.

Reads are combinational. Writes take effect at the clock edge where `bus_wen` is high.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the raw status, the enable register and `irq_o` are all zero, and every address reads zero.
- R2: A 1 on bit i of `evt_i` in cycle n makes raw bit i read as 1 from address 1 (raw view) from cycle n+1 onward, whatever the enable holds.
- R3: Address 0 (masked status) reads the raw status ANDed bit by bit with the enable register.
- R4: `irq_o` in cycle n+1 equals the OR of all masked status bits in cycle n.
- R5: A write to address 0 clears each raw bit whose data bit is 1 and whose enable is 1. Bits written 0, and bits whose enable is 0, keep their value.
- R6: A write to address 1 clears each raw bit whose data bit is 1, whatever the enable holds. Bits written 0 are unchanged.
- R7: When an event and a write-1 clear hit the same raw bit in the same cycle, the bit ends up set.
- R8: A write to address 2 sets each enable bit whose data bit is 1. Bits written 0 keep their value.
- R9: A write to address 3 clears each enable bit whose data bit is 1. Bits written 0 keep their value.
- R10: Reads of address 2 and of address 3 both return the current enable register.
- R11: After some masked bits are acknowledged, `irq_o` stays or becomes high while any other enabled raw bit is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 32 | Per-source event pulses, one cycle each |
| bus_addr | input | 2 | Word address: 0 masked status, 1 raw status, 2 enable set, 3 enable clear |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Almost all of the block's state is directly visible on the bus. A raw or enable bit that is held wrong shows up on the very next read of address 1 or 2. A wrong mask shows up as a mismatch between the reads of address 0 and address 1. A wrong clear priority, or a clear that reaches disabled bits, changes the raw view one cycle after the offending write. An error in the request path appears on `irq_o` two cycles after the event or the acknowledge that should have moved it: one cycle into the status register and one through the line register.

// File: rtl/irq_status_pkg.sv
// Package: shared register address encoding for the interrupt status controller.
// Assumes a word-addressed bus with exactly four registers.
package irq_status_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASKED = 2'd0,   // masked status, write 1 clears enabled bits
        REG_RAW    = 2'd1,   // raw status, write 1 clears any bit
        REG_EN_SET = 2'd2,   // write 1 sets enable, read returns enable
        REG_EN_CLR = 2'd3    // write 1 clears enable, read returns enable
    } reg_addr_e;

endpackage

// File: rtl/irq_raw_store.sv
// Module: sticky raw event register. One flop per source, built with generate.
// Each bit sets on an event pulse and clears on a write-1 request.
// An event beats a clear that lands in the same cycle.
// Assumes clr_i is already qualified by the bus decoder.
module irq_raw_store #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] raw_o
);

    logic [NSRC-1:0] raw_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Per-bit sticky flop: the event takes priority over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        raw_q[i] <= 1'b0;
            else if (evt_i[i]) raw_q[i] <= 1'b1;
            else if (clr_i[i]) raw_q[i] <= 1'b0;
        end
    end

    assign raw_o = raw_q;

    // R7 and R2: every bit that saw an event is set in the next cycle.
    a_r7_event_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    // R5 and R6: a cleared bit with no competing event reads zero afterwards.
    a_r6_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((raw_q & $past(clr_i & ~evt_i)) == '0));

    // R2: with no event and no clear, the register holds its value.
    a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt_i) && !(|clr_i)) |=> $stable(raw_q));

endmodule

// File: rtl/irq_enable_reg.sv
// Module: per-source enable register, changed only through set and clear masks.
// Assumes set_i and clr_i are never both nonzero in one cycle.
// The decoder guarantees this, because they come from different addresses.
module irq_enable_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] en_o
);

    logic [NSRC-1:0] en_q;

    // Apply the set mask, then the clear mask. Zero bits in either mask leave en_q alone.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_i) & ~clr_i;
    end

    assign en_o = en_q;

    // R8: set bits read as one on the next cycle.
    a_r8_set_lands : assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((en_q & $past(set_i)) == $past(set_i)));

    // R9: cleared bits read as zero on the next cycle.
    a_r9_clr_lands : assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((en_q & $past(clr_i)) == '0));

    // R8 and R9: with no request, the enables are stable.
    a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_i) && !(|clr_i)) |=> $stable(en_q));

endmodule

// File: rtl/irq_line_gen.sv
// Module: reduces the masked status to one request bit and registers it.
// Assumes the masked vector settles within the cycle.
module irq_line_gen #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] masked_i,
    output logic            irq_o
);

    logic irq_q;

    // Register the OR of all pending enabled sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked_i;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top level of the masked interrupt status controller.
// Decodes bus writes into raw-clear, enable-set and enable-clear masks.
// Muxes the read data and drives the registered request line.
// Assumes one bus access per cycle, with combinational reads.
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o
);

    reg_addr_e       addr;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] raw_clr;
    logic [NSRC-1:0] en_set;
    logic [NSRC-1:0] en_clr;

    assign addr   = reg_addr_e'(bus_addr);
    assign masked = raw & en;

    // Write decode: the masked-status address clears only enabled bits.
    always_comb begin
        raw_clr = '0;
        en_set  = '0;
        en_clr  = '0;
        if (bus_wen) begin
            unique case (addr)
                REG_MASKED: raw_clr = bus_wdata & en;
                REG_RAW:    raw_clr = bus_wdata;
                REG_EN_SET: en_set  = bus_wdata;
                REG_EN_CLR: en_clr  = bus_wdata;
                default:    ;
            endcase
        end
    end

    // Read mux: both enable addresses return the enable register.
    always_comb begin
        unique case (addr)
            REG_MASKED: bus_rdata = masked;
            REG_RAW:    bus_rdata = raw;
            default:    bus_rdata = en;
        endcase
    end

    irq_raw_store #(.NSRC(NSRC)) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (raw_clr),
        .raw_o (raw)
    );

    irq_enable_reg #(.NSRC(NSRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en)
    );

    irq_line_gen #(.NSRC(NSRC)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .masked_i (masked),
        .irq_o    (irq_o)
    );

    // R4 and R11: the line follows the previous cycle's masked status.
    a_r4_line_follows : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(raw & en))));

    // R5: a masked-status clear never touches a disabled raw bit.
    a_r5_disabled_kept : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && addr == REG_MASKED) |=>
            ((raw & $past(raw & ~en)) == $past(raw & ~en)));

endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver tasks push expected items into a queue.
// A negedge monitor pops each item and compares it with the ports.
module irq_status_ctrl_test;

    localparam int NSRC = 32;

    typedef struct {
        logic [NSRC-1:0] exp;
        bit              is_irq;
        string           tag;
    } sb_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic [1:0]      bus_addr = '0;
    logic            bus_wen = 1'b0;
    logic [NSRC-1:0] bus_wdata = '0;
    logic [NSRC-1:0] bus_rdata;
    logic            irq_o;

    int       n_checks = 0;
    int       n_errors = 0;
    bit       finished = 1'b0;
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.NSRC(NSRC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // One-cycle driver: applies all inputs shortly after the rising edge.
    task automatic drive(input logic [NSRC-1:0] ev, input logic we,
                         input logic [1:0] a, input logic [NSRC-1:0] wd);
        @(posedge clk);
        #1;
        evt_i = ev; bus_wen = we; bus_addr = a; bus_wdata = wd;
    endtask

    task automatic check_rd(input logic [1:0] a, input logic [NSRC-1:0] e, input string tag);
        sb_item_t it;
        drive('0, 1'b0, a, '0);
        it.exp = e; it.is_irq = 1'b0; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check_irq(input logic e, input string tag);
        sb_item_t it;
        drive('0, 1'b0, 2'd0, '0);
        it.exp = {{(NSRC-1){1'b0}}, e}; it.is_irq = 1'b1; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares each queued expectation in the middle of its cycle.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [NSRC-1:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {{(NSRC-1){1'b0}}, irq_o} : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: %s actual %h expected %h", it.tag,
                         it.is_irq ? "irq_o" : "rdata", act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) drive('0, 1'b0, 2'd0, '0);
        rst_n = 1'b1;
        // R1: every register clear after reset.
        check_rd(2'd0, 32'h0, "R1");
        check_rd(2'd1, 32'h0, "R1");
        check_rd(2'd2, 32'h0, "R1");
        check_irq(1'b0, "R1");
        // R2, R3: an event is visible raw, but masked while disabled.
        drive(32'h0000_0011, 1'b0, 2'd0, '0);
        check_rd(2'd1, 32'h0000_0011, "R2");
        check_rd(2'd0, 32'h0, "R3");
        check_irq(1'b0, "R4");
        // R8, R10, R3, R4: enable through the set address.
        drive('0, 1'b1, 2'd2, 32'h0000_0101);
        check_rd(2'd2, 32'h0000_0101, "R8");
        check_rd(2'd3, 32'h0000_0101, "R10");
        check_rd(2'd0, 32'h0000_0001, "R3");
        check_irq(1'b1, "R4");
        drive('0, 1'b1, 2'd2, 32'h0000_0010);
        check_rd(2'd2, 32'h0000_0111, "R8");
        // Raw becomes 0x1000_0111; bit 28 stays disabled.
        drive(32'h1000_0100, 1'b0, 2'd0, '0);
        check_rd(2'd0, 32'h0000_0111, "R3");
        // R5, R11: clear bit 0 and disabled bit 28 through the masked address.
        drive('0, 1'b1, 2'd0, 32'h1000_0001);
        check_rd(2'd1, 32'h1000_0110, "R5");
        check_rd(2'd0, 32'h0000_0110, "R5");
        check_irq(1'b1, "R11");
        drive('0, 1'b1, 2'd0, 32'h0000_0110);
        check_rd(2'd0, 32'h0, "R5");
        check_irq(1'b0, "R4");
        // R6: the raw address clears a disabled bit.
        drive('0, 1'b1, 2'd1, 32'h1000_0000);
        check_rd(2'd1, 32'h0, "R6");
        // R9, R10: clear through the clear address; zero bits keep their value.
        drive('0, 1'b1, 2'd3, 32'h0000_0100);
        check_rd(2'd3, 32'h0000_0011, "R9");
        check_rd(2'd2, 32'h0000_0011, "R10");
        // R7: an event beats a same-cycle clear; the other cleared bit drops.
        drive(32'h0000_0003, 1'b0, 2'd0, '0);
        drive(32'h0000_0001, 1'b1, 2'd1, 32'h0000_0003);
        check_rd(2'd1, 32'h0000_0001, "R7");
        // R11: the line stays up while bit 4 is still pending.
        drive(32'h0000_0010, 1'b0, 2'd0, '0);
        drive('0, 1'b1, 2'd0, 32'h0000_0001);
        check_irq(1'b1, "R11");
        check_irq(1'b1, "R11");
        drive('0, 1'b1, 2'd0, 32'h0000_0010);
        drive('0, 1'b0, 2'd0, '0);
        check_irq(1'b0, "R11");
        drive('0, 1'b0, 2'd0, '0);
        drive('0, 1'b0, 2'd0, '0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule